// File: doc/BRIEF.md
# DMA Channel Fault Handler

This block sits beside the channel threads and the manager thread of a multi-channel DMA engine and turns their fault events into an abort sequence. Each channel reports one-cycle pulses for four causes: an error response to a data load, an error response to a data store, a fault in the shared data FIFO (a load that finds too little free space, or a store that finds too little buffered data for its bus transaction), and a watchdog abort request. The manager thread reports its own error pulses. Every cause lands in a sticky status bit that software reads through a thread-select port and clears by writing ones.

When a channel goes from clean to faulting, the block holds the channel's instruction execution through a halt level. It also sends a single pulse to invalidate that channel's cache entries and a single pulse to discard the read and write queue entries that have not yet reached the bus. Bus transactions already in progress are left to finish: the flush pulse affects only queued entries. The channel program counter copy is loaded with the faulting instruction address only when the abort is flagged precise. A manager fault raises only the shared interrupt. A build parameter decides whether a watchdog request aborts its channel or is only reported as a manager-level lockup.

Top module: `dma_fault_ctl`

## Requirements
- R1: A cause pulse on a channel sets its sticky status bit one edge later, at bit 0 for load error, bit 1 for store error, bit 2 for data FIFO fault and bit 3 for watchdog (abort variant). Causes that arrive in the same cycle are all recorded, and `rd_fault_o` shows whether the selected thread has any bit set.
- R2: `halt_o[i]` is high exactly while channel i has any status bit set. It rises on the edge that records the first cause.
- R3: On entry into the faulting state, `inval_o[i]` and `flush_o[i]` each pulse high for one cycle. Causes that arrive while the channel is already faulting produce no further pulse.
- R4: On entry, `pc_o[i]` loads the faulting instruction address if `precise_i[i]` is high and is otherwise left unchanged. It does not change while the channel stays faulting.
- R5: `irq_o` is high exactly while any status bit of any thread is set.
- R6: A write with `clr_we_i` high clears the bits of thread `clr_sel_i` that are set in `clr_mask_i` (channel i at select i, manager at select NCH) and leaves other bits alone. A cause arriving in the same cycle as its clear stays set.
- R7: `kill_i[i]` clears every status bit of channel i, so halt drops one edge later. A cause arriving in the same cycle stays set, and it gives no new entry pulse if the channel was faulting.
- R8: Manager error pulse k sets manager status bit k, read at select NCH. It raises `irq_o` but gives no halt, invalidate or flush pulse on any channel.
- R9: With WDOG_ABORT=0, a channel watchdog request sets manager status bit MCW and the interrupt, and it leaves the channel untouched. With WDOG_ABORT=1, the request aborts the channel through status bit 3.
- R10: After reset, all status bits, halts, pulses, the interrupt and every program counter copy are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_err_i | input | NCH | Load error response pulse per channel |
| st_err_i | input | NCH | Store error response pulse per channel |
| fifo_err_i | input | NCH | Shared data FIFO fault pulse per channel |
| wdog_req_i | input | NCH | Watchdog abort request per channel |
| precise_i | input | NCH | Abort is precise for this channel |
| fault_pc_i | input | NCH x AW | Address of the faulting instruction per channel |
| mgr_err_i | input | MCW | Manager thread error pulses |
| clr_we_i | input | 1 | Write-one-to-clear strobe |
| clr_sel_i | input | SW | Thread targeted by the clear |
| clr_mask_i | input | SRW | Bits to clear |
| kill_i | input | NCH | Kill command per channel |
| rd_sel_i | input | SW | Thread whose status is read |
| rd_status_o | output | SRW | Status bits of the selected thread |
| rd_fault_o | output | 1 | Selected thread is faulting |
| irq_o | output | 1 | Shared fault interrupt |
| halt_o | output | NCH | Stop instruction execution per channel |
| inval_o | output | NCH | Invalidate-cache pulse per channel |
| flush_o | output | NCH | Discard-queued-requests pulse per channel |
| pc_o | output | NCH x AW | Captured program counter per channel |

## Verification
The main instance uses four channels, 32-bit addresses, two manager causes and watchdog abort enabled. With these values every cause bit, every clear target including the manager slot, and collisions between causes, clears and kills on neighbouring channels can all occur. A second instance with two channels and WDOG_ABORT=0 covers the interrupt-only watchdog variant and the manager lockup bit that only this build can set.

// File: rtl/dfh_pkg.sv
package dfh_pkg;

   // Channel cause bit positions; software decodes these positions.
   typedef enum int unsigned {
      CZ_LD   = 0,
      CZ_ST   = 1,
      CZ_FIFO = 2,
      CZ_WDOG = 3
   } cz_e;

   localparam int CW = 4;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dfh_chan.sv
module dfh_chan
   import dfh_pkg::*;
#(
   parameter int AW         = 32,
   parameter bit WDOG_ABORT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_i,
   input  logic          st_i,
   input  logic          fifo_i,
   input  logic          wdog_i,
   input  logic          precise_i,
   input  logic [AW-1:0] addr_i,
   input  logic          clr_i,
   input  logic [CW-1:0] clr_mask_i,
   input  logic          kill_i,
   output logic [CW-1:0] stat_o,
   output logic          halt_o,
   output logic          inval_o,
   output logic          flush_o,
   output logic [AW-1:0] pc_o
);

   logic          wd_cz;
   logic [CW-1:0] cz;
   logic [CW-1:0] stat_q, stat_d, keep;
   logic          entry;
   logic          inval_q, flush_q;
   logic [AW-1:0] pc_q;

   // Watchdog variant: abort the channel, or leave it to the manager.
   generate
      if (WDOG_ABORT) begin : g_wd_abort
         assign wd_cz = wdog_i;
      end else begin : g_wd_irq
         assign wd_cz = wdog_i & 1'b0;
      end
   endgenerate

   always_comb begin
      cz          = '0;
      cz[CZ_LD]   = ld_i;
      cz[CZ_ST]   = st_i;
      cz[CZ_FIFO] = fifo_i;
      cz[CZ_WDOG] = wd_cz;
   end

   always_comb begin
      keep = kill_i ? '0 : stat_q;
      if (clr_i) keep = keep & ~clr_mask_i;
      stat_d = keep | cz;
   end

   assign entry = ~(|stat_q) & (|cz);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q  <= '0;
         inval_q <= 1'b0;
         flush_q <= 1'b0;
         pc_q    <= '0;
      end else begin
         stat_q  <= stat_d;
         inval_q <= entry;
         flush_q <= entry;
         if (entry && precise_i) pc_q <= addr_i;
      end
   end

   assign stat_o  = stat_q;
   assign halt_o  = |stat_q;
   assign inval_o = inval_q;
   assign flush_o = flush_q;
   assign pc_o    = pc_q;

endmodule

// File: rtl/dfh_mgr.sv
module dfh_mgr #(
   parameter int MCW        = 2,
   parameter int NCH        = 4,
   parameter bit WDOG_ABORT = 1'b1,
   localparam int MSW       = MCW + 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [MCW-1:0] err_i,
   input  logic [NCH-1:0] wdog_i,
   input  logic           clr_i,
   input  logic [MSW-1:0] clr_mask_i,
   output logic [MSW-1:0] stat_o
);

   logic           lock;
   logic [MSW-1:0] stat_q, stat_d;

   generate
      if (WDOG_ABORT) begin : g_lock_off
         assign lock = (|wdog_i) & 1'b0;
      end else begin : g_lock_on
         assign lock = |wdog_i;
      end
   endgenerate

   always_comb begin
      stat_d = stat_q;
      if (clr_i) stat_d = stat_d & ~clr_mask_i;
      stat_d = stat_d | {lock, err_i};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_d;
   end

   assign stat_o = stat_q;

endmodule

// File: rtl/dfh_rdmux.sv
module dfh_rdmux
   import dfh_pkg::*;
#(
   parameter int NCH = 4,
   parameter int MSW = 3,
   parameter int SRW = 4,
   parameter int SW  = 3
) (
   input  logic [NCH-1:0][CW-1:0] chan_stat_i,
   input  logic [MSW-1:0]         mgr_stat_i,
   input  logic [SW-1:0]          rd_sel_i,
   output logic [SRW-1:0]         rd_status_o,
   output logic                   rd_fault_o,
   output logic                   irq_o
);

   always_comb begin
      rd_status_o = '0;
      for (int i = 0; i < NCH; i++) begin
         if (rd_sel_i == SW'(i)) rd_status_o[CW-1:0] = chan_stat_i[i];
      end
      if (rd_sel_i == SW'(NCH)) rd_status_o[MSW-1:0] = mgr_stat_i;
   end

   assign rd_fault_o = |rd_status_o;
   assign irq_o      = (|chan_stat_i) | (|mgr_stat_i);

endmodule

// File: rtl/dma_fault_ctl.sv
module dma_fault_ctl
   import dfh_pkg::*;
#(
   parameter int NCH        = 4,
   parameter int AW         = 32,
   parameter int MCW        = 2,
   parameter bit WDOG_ABORT = 1'b1,
   localparam int MSW       = MCW + 1,
   localparam int SRW       = imax(CW, MSW),
   localparam int SW        = $clog2(NCH + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NCH-1:0]         ld_err_i,
   input  logic [NCH-1:0]         st_err_i,
   input  logic [NCH-1:0]         fifo_err_i,
   input  logic [NCH-1:0]         wdog_req_i,
   input  logic [NCH-1:0]         precise_i,
   input  logic [NCH-1:0][AW-1:0] fault_pc_i,
   input  logic [MCW-1:0]         mgr_err_i,
   input  logic                   clr_we_i,
   input  logic [SW-1:0]          clr_sel_i,
   input  logic [SRW-1:0]         clr_mask_i,
   input  logic [NCH-1:0]         kill_i,
   input  logic [SW-1:0]          rd_sel_i,
   output logic [SRW-1:0]         rd_status_o,
   output logic                   rd_fault_o,
   output logic                   irq_o,
   output logic [NCH-1:0]         halt_o,
   output logic [NCH-1:0]         inval_o,
   output logic [NCH-1:0]         flush_o,
   output logic [NCH-1:0][AW-1:0] pc_o
);

   generate
      if (NCH < 1 || NCH > 64) begin : g_bad_nch
         $error("dma_fault_ctl: NCH must lie in 1..64");
      end
      if (AW < 2) begin : g_bad_aw
         $error("dma_fault_ctl: AW must be at least 2");
      end
      if (MCW < 1 || MCW > 16) begin : g_bad_mcw
         $error("dma_fault_ctl: MCW must lie in 1..16");
      end
   endgenerate

   logic [NCH-1:0][CW-1:0] chan_stat;
   logic [MSW-1:0]         mgr_stat;

   genvar gi;
   generate
      for (gi = 0; gi < NCH; gi++) begin : g_ch
         logic clr_hit;
         assign clr_hit = clr_we_i && (clr_sel_i == SW'(gi));

         dfh_chan #(
            .AW         (AW),
            .WDOG_ABORT (WDOG_ABORT)
         ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .ld_i       (ld_err_i[gi]),
            .st_i       (st_err_i[gi]),
            .fifo_i     (fifo_err_i[gi]),
            .wdog_i     (wdog_req_i[gi]),
            .precise_i  (precise_i[gi]),
            .addr_i     (fault_pc_i[gi]),
            .clr_i      (clr_hit),
            .clr_mask_i (clr_mask_i[CW-1:0]),
            .kill_i     (kill_i[gi]),
            .stat_o     (chan_stat[gi]),
            .halt_o     (halt_o[gi]),
            .inval_o    (inval_o[gi]),
            .flush_o    (flush_o[gi]),
            .pc_o       (pc_o[gi])
         );
      end
   endgenerate

   logic mgr_clr;
   assign mgr_clr = clr_we_i && (clr_sel_i == SW'(NCH));

   dfh_mgr #(
      .MCW        (MCW),
      .NCH        (NCH),
      .WDOG_ABORT (WDOG_ABORT)
   ) u_mgr (
      .clk        (clk),
      .rst_n      (rst_n),
      .err_i      (mgr_err_i),
      .wdog_i     (wdog_req_i),
      .clr_i      (mgr_clr),
      .clr_mask_i (clr_mask_i[MSW-1:0]),
      .stat_o     (mgr_stat)
   );

   dfh_rdmux #(
      .NCH (NCH),
      .MSW (MSW),
      .SRW (SRW),
      .SW  (SW)
   ) u_rd (
      .chan_stat_i (chan_stat),
      .mgr_stat_i  (mgr_stat),
      .rd_sel_i    (rd_sel_i),
      .rd_status_o (rd_status_o),
      .rd_fault_o  (rd_fault_o),
      .irq_o       (irq_o)
   );

endmodule

// File: rtl/dfh_chk.sv
module dfh_chk #(
   parameter int NCH = 4,
   parameter int AW  = 32,
   parameter int MCW = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NCH-1:0]         ld_err_i,
   input logic [NCH-1:0]         st_err_i,
   input logic [NCH-1:0]         fifo_err_i,
   input logic [NCH-1:0]         wdog_req_i,
   input logic [NCH-1:0]         kill_i,
   input logic [MCW-1:0]         mgr_err_i,
   input logic                   irq_o,
   input logic [NCH-1:0]         halt_o,
   input logic [NCH-1:0]         inval_o,
   input logic [NCH-1:0]         flush_o,
   input logic [NCH-1:0][AW-1:0] pc_o
);

   // R5
   halt_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|halt_o) |-> irq_o);

   // R8
   mgr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|mgr_err_i) |=> irq_o);

   genvar gi;
   generate
      for (gi = 0; gi < NCH; gi++) begin : g_c
         // R1
         ld_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ld_err_i[gi] |=> halt_o[gi]);

         // R3
         entry_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(halt_o[gi]) |-> (inval_o[gi] && flush_o[gi]));

         // R3
         inval_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            inval_o[gi] |=> !inval_o[gi]);

         // R3
         inval_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (inval_o[gi] || flush_o[gi]) |-> halt_o[gi]);

         // R4
         pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (halt_o[gi] && $past(halt_o[gi])) |-> $stable(pc_o[gi]));

         // R7
         kill_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (kill_i[gi] && !ld_err_i[gi] && !st_err_i[gi] && !fifo_err_i[gi]
             && !wdog_req_i[gi]) |=> !halt_o[gi]);
      end
   endgenerate

endmodule

bind dma_fault_ctl dfh_chk #(
   .NCH (NCH),
   .AW  (AW),
   .MCW (MCW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ld_err_i   (ld_err_i),
   .st_err_i   (st_err_i),
   .fifo_err_i (fifo_err_i),
   .wdog_req_i (wdog_req_i),
   .kill_i     (kill_i),
   .mgr_err_i  (mgr_err_i),
   .irq_o      (irq_o),
   .halt_o     (halt_o),
   .inval_o    (inval_o),
   .flush_o    (flush_o),
   .pc_o       (pc_o)
);

// File: tb/sim_dma_fault_ctl.sv
`timescale 1ns/100ps
module sim_dma_fault_ctl;

   localparam int NCH = 4;
   localparam int AW  = 32;
   localparam int MCW = 2;
   localparam int SW  = 3;
   localparam int SRW = 4;

   logic clk = 1'b0;
   always #4 clk = ~clk;
   logic rst_n = 1'b0;

   int n_chk = 0;
   int n_bad = 0;

   // main instance
   logic [NCH-1:0]         ld, st, ff, wd, pr, kl;
   logic [NCH-1:0][AW-1:0] addr;
   logic [MCW-1:0]         merr;
   logic                   cwe;
   logic [SW-1:0]          csel, rsel;
   logic [SRW-1:0]         cmask;
   logic [SRW-1:0]         rstat;
   logic                   rfault, irq;
   logic [NCH-1:0]         halt, inval, flush;
   logic [NCH-1:0][AW-1:0] pc;

   dma_fault_ctl #(.NCH(NCH), .AW(AW), .MCW(MCW), .WDOG_ABORT(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .ld_err_i(ld), .st_err_i(st), .fifo_err_i(ff),
      .wdog_req_i(wd), .precise_i(pr), .fault_pc_i(addr), .mgr_err_i(merr),
      .clr_we_i(cwe), .clr_sel_i(csel), .clr_mask_i(cmask), .kill_i(kl),
      .rd_sel_i(rsel), .rd_status_o(rstat), .rd_fault_o(rfault), .irq_o(irq),
      .halt_o(halt), .inval_o(inval), .flush_o(flush), .pc_o(pc));

   // interrupt-only watchdog instance
   logic [1:0]         b_z, b_wd;
   logic [1:0][AW-1:0] b_addr;
   logic [MCW-1:0]     b_merr;
   logic               b_cwe;
   logic [1:0]         b_csel, b_rsel;
   logic [3:0]         b_cmask, b_rstat;
   logic               b_rfault, b_irq;
   logic [1:0]         b_halt, b_inval, b_flush;
   logic [1:0][AW-1:0] b_pc;

   dma_fault_ctl #(.NCH(2), .AW(AW), .MCW(MCW), .WDOG_ABORT(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .ld_err_i(b_z), .st_err_i(b_z), .fifo_err_i(b_z),
      .wdog_req_i(b_wd), .precise_i(b_z), .fault_pc_i(b_addr), .mgr_err_i(b_merr),
      .clr_we_i(b_cwe), .clr_sel_i(b_csel), .clr_mask_i(b_cmask), .kill_i(b_z),
      .rd_sel_i(b_rsel), .rd_status_o(b_rstat), .rd_fault_o(b_rfault), .irq_o(b_irq),
      .halt_o(b_halt), .inval_o(b_inval), .flush_o(b_flush), .pc_o(b_pc));

   // expected state
   logic [3:0]    m_stat [NCH];
   logic [AW-1:0] m_pc   [NCH];
   logic [2:0]    m_mgr;
   logic [NCH-1:0] m_strb;
   bit            done = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [3:0] nx_stat(input logic [3:0] cur, input logic [3:0] cz,
                                          input bit clr, input logic [3:0] mask,
                                          input bit kill);
      logic [3:0] r;
      r = kill ? 4'b0 : cur;
      if (clr) r = r & ~mask;
      return r | cz;
   endfunction

   function automatic logic [2:0] nx_mgr(input logic [2:0] cur, input logic [MCW-1:0] e,
                                         input bit clr, input logic [2:0] mask);
      logic [2:0] r;
      r = clr ? (cur & ~mask) : cur;
      return r | {1'b0, e};
   endfunction

   task automatic idle_in();
      ld = '0; st = '0; ff = '0; wd = '0; pr = '0; kl = '0; merr = '0;
      cwe = 1'b0; csel = '0; cmask = '0;
   endtask

   task automatic rd(input int s, output logic [3:0] v);
      rsel = SW'(s);
      #0.2;
      v = rstat;
   endtask

   task automatic check_all(input string ph);
      logic [3:0] v, e;
      bit any;
      any = |m_mgr;
      for (int i = 0; i < NCH; i++) begin
         any = any | (|m_stat[i]);
         chk(halt[i] == (|m_stat[i]), {"R2 halt ", ph}, halt[i], |m_stat[i]);
         chk(inval[i] == m_strb[i], {"R3 inval ", ph}, inval[i], m_strb[i]);
         chk(flush[i] == m_strb[i], {"R3 flush ", ph}, flush[i], m_strb[i]);
         chk(pc[i] == m_pc[i], {"R4 pc ", ph}, pc[i], m_pc[i]);
      end
      chk(irq == any, {"R5 irq ", ph}, irq, any);
      for (int s = 0; s <= NCH; s++) begin
         rd(s, v);
         e = (s < NCH) ? m_stat[s] : {1'b0, m_mgr};
         chk(v == e, (s < NCH) ? {"R1 status ", ph} : {"R8 mgr status ", ph}, v, e);
         chk(rfault == (|e), {"R1 rd_fault ", ph}, rfault, |e);
      end
   endtask

   // Apply the inputs already set for one edge, update the model, then check.
   task automatic cyc(input string ph);
      logic [3:0]    n_stat [NCH];
      logic [AW-1:0] n_pc   [NCH];
      logic [NCH-1:0] ent;
      logic [2:0]    n_mgr;
      for (int i = 0; i < NCH; i++) begin
         logic [3:0] cz;
         cz = {wd[i], ff[i], st[i], ld[i]};
         ent[i] = (m_stat[i] == 4'b0) && (cz != 4'b0);
         n_stat[i] = nx_stat(m_stat[i], cz, cwe && (csel == SW'(i)), cmask, kl[i]);
         n_pc[i] = (ent[i] && pr[i]) ? addr[i] : m_pc[i];
      end
      n_mgr = nx_mgr(m_mgr, merr, cwe && (csel == SW'(NCH)), cmask[2:0]);
      @(posedge clk);
      #1;
      for (int i = 0; i < NCH; i++) begin
         m_stat[i] = n_stat[i];
         m_pc[i] = n_pc[i];
      end
      m_mgr = n_mgr;
      m_strb = ent;
      idle_in();
      check_all(ph);
   endtask

   task automatic clear_all();
      for (int s = 0; s <= NCH; s++) begin
         cwe = 1'b1; csel = SW'(s); cmask = '1;
         cyc("clear");
      end
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired act=1 exp=0");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [3:0] v;
      void'($urandom(32'h5eed_0b1d));
      idle_in();
      addr = '0; rsel = '0;
      b_z = '0; b_wd = '0; b_addr = '0; b_merr = '0; b_cwe = 1'b0;
      b_csel = '0; b_cmask = '0; b_rsel = '0;
      for (int i = 0; i < NCH; i++) begin
         m_stat[i] = '0; m_pc[i] = '0;
      end
      m_mgr = '0; m_strb = '0;
      repeat (3) @(posedge clk);
      #1;
      // R10: reset state
      check_all("R10 reset");
      rst_n = 1'b1;
      @(posedge clk); #1;
      check_all("R10 after release");

      // R1: three causes in one cycle, precise
      ld[0] = 1; st[0] = 1; ff[0] = 1; pr[0] = 1; addr[0] = 32'hA000_0010;
      cyc("R1 multi");
      rd(0, v);
      chk(v == 4'b0111, "R1 all same-cycle causes", v, 4'b0111);
      chk(pc[0] == 32'hA000_0010, "R4 precise capture", pc[0], 32'hA000_0010);

      // R4: imprecise entry leaves pc; later precise cause while faulting ignored
      st[1] = 1; pr[1] = 0; addr[1] = 32'hBBBB_0000;
      cyc("R4 imprecise");
      chk(pc[1] == 32'h0, "R4 imprecise keeps pc", pc[1], 0);
      ff[1] = 1; pr[1] = 1; addr[1] = 32'hCCCC_0004;
      cyc("R4 refault");
      chk(inval[1] == 1'b0, "R3 no pulse while faulting", inval[1], 0);
      chk(pc[1] == 32'h0, "R4 pc held while faulting", pc[1], 0);

      // R6: clear collides with a new cause; then partial clear
      cwe = 1; csel = 0; cmask = 4'b0001; ld[0] = 1;
      cyc("R6 set wins");
      rd(0, v);
      chk(v == 4'b0111, "R6 set beats clear", v, 4'b0111);
      cwe = 1; csel = 0; cmask = 4'b0110;
      cyc("R6 partial");
      rd(0, v);
      chk(v == 4'b0001, "R6 unmasked bits kept", v, 4'b0001);

      // R7: kill with a same-cycle cause, then plain kill
      kl[1] = 1; st[1] = 1;
      cyc("R7 kill+cause");
      rd(1, v);
      chk(v == 4'b0010, "R7 cause survives kill", v, 4'b0010);
      chk(inval[1] == 1'b0, "R7 no new entry pulse", inval[1], 0);
      kl[1] = 1;
      cyc("R7 kill");
      chk(halt[1] == 1'b0, "R7 halt released", halt[1], 0);

      // R8: manager fault only interrupts
      merr = 2'b10;
      cyc("R8 mgr");
      rd(NCH, v);
      chk(v == 4'b0010, "R8 manager bit", v, 4'b0010);
      chk(halt[3:1] == 3'b0 && inval == '0, "R8 no channel abort", {halt, inval}, 0);

      // R9: watchdog aborts channel in abort build
      wd[2] = 1; pr[2] = 1; addr[2] = 32'h0000_2224;
      cyc("R9 wdog abort");
      rd(2, v);
      chk(v == 4'b1000 && halt[2], "R9 watchdog aborts channel", {halt[2], v}, 5'h18);

      clear_all();
      chk(irq == 1'b0, "R6 all cleared drops irq", irq, 0);

      // random phase
      for (int n = 0; n < 3000; n++) begin
         for (int i = 0; i < NCH; i++) begin
            ld[i] = ($urandom % 16) == 0;
            st[i] = ($urandom % 16) == 0;
            ff[i] = ($urandom % 16) == 0;
            wd[i] = ($urandom % 24) == 0;
            pr[i] = $urandom % 2;
            kl[i] = ($urandom % 12) == 0;
            addr[i] = $urandom;
         end
         merr = (($urandom % 10) == 0) ? MCW'($urandom) : '0;
         cwe = ($urandom % 4) == 0;
         csel = SW'($urandom % (NCH + 1));
         cmask = SRW'($urandom);
         cyc("random");
      end

      // R9: interrupt-only watchdog build
      b_wd[1] = 1'b1;
      @(posedge clk); #1;
      b_wd = '0;
      b_rsel = 2'd2; #0.2;
      chk(b_rstat == 4'b0100, "R9 lockup bit in manager", b_rstat, 4'b0100);
      chk(b_irq == 1'b1, "R9 lockup raises irq", b_irq, 1);
      chk(b_halt == 2'b00 && b_inval == 2'b00 && b_flush == 2'b00,
          "R9 channel untouched", {b_halt, b_inval, b_flush}, 0);
      b_rsel = 2'd1; #0.2;
      chk(b_rstat == 4'b0000, "R9 channel status empty", b_rstat, 0);
      b_cwe = 1'b1; b_csel = 2'd2; b_cmask = 4'b0100;
      @(posedge clk); #1;
      b_cwe = 1'b0;
      chk(b_irq == 1'b0, "R6 lockup cleared", b_irq, 0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule